// File: doc/BRIEF.md
# Memory Test Traffic Checker

This block drives write and read traffic into a memory port and checks what comes back. Once started, it writes a programmed number of consecutive words beginning at address 0. It then reads the same addresses back in the same order and compares each returned word against the value it should hold. It repeats this write-then-read pass until it is told to stop.

Write data comes from one of two sources. The first is a PRBS-31 word generator. The second is a 16-entry pattern table that is computed in logic. The checker rebuilds the expected data on its own side, so the read responses only need to arrive in order.

A host can ask for a one-word error to be injected while a test runs. Two saturating counters report the words that were injected and the words that were detected as wrong, and a clear strobe zeroes both counters.

Top module: `mem_traffic_checker`

## Requirements
- R1: After reset, `busy` is 0, `req_valid` is 0 and both error counters read 0.
- R2: In each pass the block writes addresses 0 to N-1 in ascending order, then reads addresses 0 to N-1 in ascending order. N is `cfg_words` sampled at the start of the pass. Request address and direction stay stable while `req_valid` is high and `req_ready` is low.
- R3: With `cfg_prbs`=1, write word i of a pass is the i-th 32-bit group of PRBS-31 output bits. The generator uses x^31+x^28+1, so each new bit is s[30]^s[27] shifted into s[0]. It starts from 31'h2545F491 at the start of every pass, and each word collects 32 new bits MSB first.
- R4: With `cfg_prbs`=0, the word at address a is the byte {a[3:0], ~a[3:0]} repeated four times.
- R5: `detected_cnt` increases by one for each read response that differs from the expected word.
- R6: A pulse on `insert_err` while `busy` inverts bit 0 of the next write word and increments `inserted_cnt`. That word is then counted as a mismatch when it is read back. A pulse while idle has no effect.
- R7: A one-cycle `clear` sets both counters to 0.
- R8: Both counters stop at their all-ones value instead of wrapping.
- R9: `busy` rises on `start` and passes repeat until `stop`. The pass in progress finishes its read phase before `busy` falls.
- R10: A `cfg_words` value below 2 runs passes of 2 words. Values above 2^24 are limited to 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin testing (used when idle) |
| stop | input | 1 | End testing after the current pass |
| clear | input | 1 | Zero both error counters |
| insert_err | input | 1 | Request one corrupted write word |
| cfg_words | input | AW+1 | Words per pass |
| cfg_prbs | input | 1 | 1: PRBS data, 0: pattern table |
| busy | output | 1 | Test running |
| detected_cnt | output | CNT_W | Mismatching read words |
| inserted_cnt | output | CNT_W | Injected write errors |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts request |
| req_write | output | 1 | 1: write, 0: read |
| req_addr | output | AW | Request word address |
| req_wdata | output | DW | Write data |
| rsp_valid | input | 1 | Read data valid (in request order) |
| rsp_rdata | input | DW | Read data |

## Verification
The hardest case to reach from the ports is an injected error that must travel through memory and come back as a counted mismatch. The injection must also land in the pass that is already running, and a request made while idle must leave no trace behind. The bench pulses `insert_err` at chosen points in the write stream, counting writes from its own bus monitor. It confirms that exactly that many write words carry bit 0 inverted and that the same number of mismatches are detected. A separate bench-side memory fault forces mismatches without injection, and with a 4-bit counter build this drives the counter into saturation.

// File: rtl/mtc_pkg.sv
// Shared types for the memory test traffic checker.
package mtc_pkg;
    // Sequencer phase: idle, issuing writes, issuing reads / collecting responses.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } mtc_state_e;

    localparam int PRBS_LEN = 31;
endpackage

// File: rtl/mtc_prbs_word.sv
// PRBS-31 word source (x^31 + x^28 + 1).
// Produces DW fresh sequence bits per word, MSB first.
// Assumes DW >= 2; load has priority over advance.
module mtc_prbs_word #(
    parameter int DW = 32,
    parameter logic [30:0] SEED = 31'h2545F491
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    output logic [DW-1:0] word
);
    import mtc_pkg::*;

    logic [PRBS_LEN-1:0] lfsr;
    logic [PRBS_LEN-1:0] lfsr_next;

    // Unroll DW shifts to form the current word and the following state.
    always_comb begin
        logic [PRBS_LEN-1:0] s;
        logic fb;
        s    = lfsr;
        word = '0;
        for (int b = 0; b < DW; b++) begin
            fb   = s[30] ^ s[27];
            s    = {s[29:0], fb};
            word = {word[DW-2:0], fb};
        end
        lfsr_next = s;
    end

    // Hold, reseed or step the register.
    always_ff @(posedge clk) begin
        if (!rst_n || load) lfsr <= SEED;
        else if (advance)   lfsr <= lfsr_next;
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0); // R3
endmodule

// File: rtl/mtc_pattern_rom.sv
// Computed 16-entry pattern table: entry i is byte {i, ~i} repeated.
// Assumes DW is a multiple of 8.
module mtc_pattern_rom #(
    parameter int DW = 32
) (
    input  logic [3:0]    idx,
    output logic [DW-1:0] word
);
    localparam int DEPTH = 16;
    localparam int REPS  = DW / 8;

    logic [DW-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic [3:0] IV = 4'(i);
        assign table_q[i] = {REPS{IV, ~IV}};
    end

    // Select the entry addressed by the low address bits.
    assign word = table_q[idx];
endmodule

// File: rtl/mtc_sat_counter.sv
// Saturating event counter with synchronous clear.
// Clear wins over a same-cycle increment.
module mtc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = '1;

    // Count up, stopping at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              count <= '0;
        else if (inc && count != MAXV)  count <= count + 1'b1;
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV && !clr) |=> count == MAXV); // R8
    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0); // R7
endmodule

// File: rtl/mem_traffic_checker.sv
// Memory test traffic checker top.
// Runs passes that write N words at addresses 0..N-1 and read them back, checks
// each response and counts injected and detected errors.
// Assumes read responses return in request order and only during the read phase.
module mem_traffic_checker #(
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int CNT_W = 32,
    parameter logic [30:0] SEED = 31'h2545F491
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             clear,
    input  logic             insert_err,
    input  logic [AW:0]      cfg_words,
    input  logic             cfg_prbs,
    output logic             busy,
    output logic [CNT_W-1:0] detected_cnt,
    output logic [CNT_W-1:0] inserted_cnt,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             req_write,
    output logic [AW-1:0]    req_addr,
    output logic [DW-1:0]    req_wdata,
    input  logic             rsp_valid,
    input  logic [DW-1:0]    rsp_rdata
);
    import mtc_pkg::*;

    localparam int          IW    = AW + 1;
    localparam logic [IW-1:0] MIN_N = IW'(2);
    localparam logic [IW-1:0] MAX_N = IW'(1) << AW;

    mtc_state_e    state;
    logic [IW-1:0] n_words, n_clamped;
    logic          src_prbs;
    logic [IW-1:0] wr_idx, rd_idx, chk_idx;
    logic          stop_req;
    logic          inj_pend, inj_valid;
    logic [AW-1:0] inj_addr;

    logic wr_hs, rd_hs, rsp_hs, wr_last, chk_last;
    logic iter_start, go_idle, inj_apply, mismatch;
    logic [DW-1:0] wr_prbs_word, chk_prbs_word, wr_pat_word, chk_pat_word;
    logic [DW-1:0] wr_word, exp_word;

    // Limit the programmed word count to the legal range.
    always_comb begin
        if (cfg_words < MIN_N)      n_clamped = MIN_N;
        else if (cfg_words > MAX_N) n_clamped = MAX_N;
        else                        n_clamped = cfg_words;
    end

    // Request port drive and handshake decode.
    always_comb begin
        busy      = (state != ST_IDLE);
        req_write = (state == ST_WRITE);
        req_valid = ((state == ST_WRITE) && (wr_idx < n_words)) ||
                    ((state == ST_READ)  && (rd_idx < n_words));
        req_addr  = req_write ? wr_idx[AW-1:0] : rd_idx[AW-1:0];
        wr_hs     = req_valid && req_ready && req_write;
        rd_hs     = req_valid && req_ready && !req_write;
        rsp_hs    = rsp_valid && (state == ST_READ);
        wr_last   = wr_hs && (wr_idx == n_words - 1'b1);
        chk_last  = rsp_hs && (chk_idx == n_words - 1'b1);
        iter_start = ((state == ST_IDLE) && start) ||
                     (chk_last && !stop_req && !stop);
        go_idle    = chk_last && (stop_req || stop);
        inj_apply  = wr_hs && inj_pend;
    end

    // Data selection on the write and check sides.
    always_comb begin
        wr_word   = src_prbs ? wr_prbs_word : wr_pat_word;
        req_wdata = {wr_word[DW-1:1], wr_word[0] ^ inj_pend};
        exp_word  = src_prbs ? chk_prbs_word : chk_pat_word;
        mismatch  = rsp_hs && (rsp_rdata != exp_word);
    end

    mtc_prbs_word #(.DW(DW), .SEED(SEED)) u_wr_prbs (
        .clk(clk), .rst_n(rst_n), .load(iter_start), .advance(wr_hs), .word(wr_prbs_word));
    mtc_prbs_word #(.DW(DW), .SEED(SEED)) u_chk_prbs (
        .clk(clk), .rst_n(rst_n), .load(wr_last), .advance(rsp_hs), .word(chk_prbs_word));
    mtc_pattern_rom #(.DW(DW)) u_wr_pat (.idx(wr_idx[3:0]), .word(wr_pat_word));
    mtc_pattern_rom #(.DW(DW)) u_chk_pat (.idx(chk_idx[3:0]), .word(chk_pat_word));

    // Phase sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)          state <= ST_IDLE;
        else if (iter_start) state <= ST_WRITE;
        else if (wr_last)    state <= ST_READ;
        else if (go_idle)    state <= ST_IDLE;
    end

    // Per-pass configuration latch and address/response indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_words  <= MIN_N;
            src_prbs <= 1'b0;
            wr_idx   <= '0;
            rd_idx   <= '0;
            chk_idx  <= '0;
        end else begin
            if (iter_start) begin
                n_words  <= n_clamped;
                src_prbs <= cfg_prbs;
                wr_idx   <= '0;
            end else if (wr_hs) begin
                wr_idx <= wr_idx + 1'b1;
            end
            if (wr_last) begin
                rd_idx  <= '0;
                chk_idx <= '0;
            end else begin
                if (rd_hs)  rd_idx  <= rd_idx + 1'b1;
                if (rsp_hs) chk_idx <= chk_idx + 1'b1;
            end
        end
    end

    // Remember a stop request until the current pass drains.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) stop_req <= 1'b0;
        else if (stop)                  stop_req <= 1'b1;
    end

    // Error injection: pending flag plus address of the last corrupted word.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) begin
            inj_pend  <= 1'b0;
            inj_valid <= 1'b0;
            inj_addr  <= '0;
        end else begin
            inj_pend <= (inj_pend && !inj_apply) || insert_err;
            if (inj_apply) begin
                inj_valid <= 1'b1;
                inj_addr  <= wr_idx[AW-1:0];
            end else if (iter_start) begin
                inj_valid <= 1'b0;
            end
        end
    end

    mtc_sat_counter #(.W(CNT_W)) u_det_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clear), .inc(mismatch), .count(detected_cnt));
    mtc_sat_counter #(.W(CNT_W)) u_inj_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clear), .inc(inj_apply), .count(inserted_cnt));

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write))); // R2
    AST_RSP_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (state == ST_READ)); // R2
    AST_INJ_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hs && inj_valid && chk_idx[AW-1:0] == inj_addr) |-> mismatch); // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !stop_req && !stop) |=> busy); // R9
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !req_valid); // R1
endmodule

// File: tb/mem_traffic_checker_test.sv
module mem_traffic_checker_test;
    localparam int AW = 24, DW = 32, CNT_W = 4, MEMD = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, stop = 0, clear = 0, insert_err = 0, cfg_prbs = 0;
    logic [AW:0] cfg_words = '0;
    logic busy, req_valid, req_ready, req_write, rsp_valid;
    logic [CNT_W-1:0] detected_cnt, inserted_cnt;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata, rsp_rdata;

    int vectors = 0, fails = 0;
    int wr_seen = 0, rd_seen = 0, iter_done = 0, flips = 0, n_exp = 2;
    logic src_exp = 0;
    logic [DW-1:0] prbs_tab [MEMD];
    logic [DW-1:0] mem [MEMD];
    logic [1:0] cyc = 0;
    logic p1_v = 0;
    logic [DW-1:0] p1_d = '0;
    logic bad_en = 0;
    int bad_addr = 0;

    always #10 clk = ~clk;

    mem_traffic_checker #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .clear(clear),
        .insert_err(insert_err), .cfg_words(cfg_words), .cfg_prbs(cfg_prbs),
        .busy(busy), .detected_cnt(detected_cnt), .inserted_cnt(inserted_cnt),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        logic [3:0] v = 4'(a);
        return {4{v, ~v}};
    endfunction

    // Behavioural memory: ready stalls one cycle in four, reads return two cycles later.
    assign req_ready = (cyc != 2'b11);
    always @(posedge clk) begin
        cyc <= cyc + 1'b1;
        if (!rst_n) begin
            p1_v <= 0; rsp_valid <= 0; rsp_rdata <= '0;
        end else begin
            if (req_valid && req_ready && req_write) mem[req_addr[5:0]] <= req_wdata;
            p1_v <= req_valid && req_ready && !req_write;
            p1_d <= mem[req_addr[5:0]] ^ ((bad_en && int'(req_addr) == bad_addr) ? 32'h8000_0000 : 32'h0);
            rsp_valid <= p1_v;
            rsp_rdata <= p1_d;
        end
    end

    // Bus monitor: order and data of every accepted request (R2, R3, R4).
    always @(posedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            int ea;
            logic [DW-1:0] e;
            if (req_write) begin
                ea = wr_seen % n_exp;
                check(int'(req_addr) == ea, "R2 write address", 64'(req_addr), 64'(ea));
                e = src_exp ? prbs_tab[ea] : pat(ea);
                if (req_wdata == (e ^ 32'h1)) flips++;
                else check(req_wdata == e, src_exp ? "R3 prbs write data" : "R4 pattern write data",
                           64'(req_wdata), 64'(e));
                wr_seen++;
            end else begin
                ea = rd_seen % n_exp;
                check(int'(req_addr) == ea, "R2 read address", 64'(req_addr), 64'(ea));
                rd_seen++;
                if (ea == n_exp - 1) iter_done++;
            end
        end
    end

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1; @(negedge clk); sig = 0;
    endtask

    task automatic begin_run(input logic src, input int cfg, input int n);
        @(negedge clk);
        cfg_prbs = src; cfg_words = (AW+1)'(cfg);
        src_exp = src; n_exp = n;
        wr_seen = 0; rd_seen = 0; iter_done = 0; flips = 0;
        pulse(start);
        check(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
    endtask

    task automatic end_run(input int iters, input string tag);
        while (iter_done < iters) begin
            @(negedge clk);
            check(busy == 1'b1, "R9 busy held until stop", 64'(busy), 64'd1);
        end
        stop = 1; @(negedge clk); stop = 0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(wr_seen == iters * n_exp, {tag, " R9 writes per run"}, 64'(wr_seen), 64'(iters * n_exp));
        check(rd_seen == iters * n_exp, {tag, " R9 reads per run"}, 64'(rd_seen), 64'(iters * n_exp));
    endtask

    task automatic t_reset();
        check(busy == 0, "R1 busy reset", 64'(busy), 0);
        check(req_valid == 0, "R1 req_valid reset", 64'(req_valid), 0);
        check(detected_cnt == 0 && inserted_cnt == 0, "R1 counters reset",
              64'({detected_cnt, inserted_cnt}), 0);
    endtask

    task automatic t_prbs();
        begin_run(1, 5, 5); end_run(2, "prbs");
        check(detected_cnt == 0, "R5 no mismatch prbs", 64'(detected_cnt), 0);
    endtask

    task automatic t_pattern();
        begin_run(0, 20, 20); end_run(1, "pattern");
        check(detected_cnt == 0, "R5 no mismatch pattern", 64'(detected_cnt), 0);
    endtask

    task automatic t_clamp();
        begin_run(1, 0, 2); end_run(2, "R10 count 0");
        begin_run(0, 1, 2); end_run(1, "R10 count 1");
    endtask

    task automatic t_inject();
        pulse(insert_err);
        repeat (4) @(negedge clk);
        check(inserted_cnt == 0, "R6 idle request ignored", 64'(inserted_cnt), 0);
        begin_run(1, 4, 4); end_run(1, "R6 after idle request");
        check(flips == 0 && inserted_cnt == 0, "R6 no stale injection", 64'(flips), 0);
        begin_run(1, 8, 8);
        while (wr_seen < 2) @(negedge clk);
        pulse(insert_err);
        while (wr_seen < 12) @(negedge clk);
        pulse(insert_err);
        end_run(3, "R6 inject");
        check(flips == 2, "R6 bit0 inverted words", 64'(flips), 2);
        check(inserted_cnt == 2, "R6 inserted count", 64'(inserted_cnt), 2);
        check(detected_cnt == 2, "R6 injected words detected", 64'(detected_cnt), 2);
    endtask

    task automatic t_clear();
        pulse(clear);
        check(detected_cnt == 0 && inserted_cnt == 0, "R7 clear both",
              64'({detected_cnt, inserted_cnt}), 0);
    endtask

    task automatic t_badmem();
        bad_en = 1; bad_addr = 3;
        begin_run(1, 6, 6); end_run(2, "R5 faulty word");
        check(detected_cnt == 2, "R5 detected faulty word", 64'(detected_cnt), 2);
        bad_en = 0;
    endtask

    task automatic t_saturate();
        bad_en = 1; bad_addr = 1;
        begin_run(0, 4, 4); end_run(20, "R8 saturate");
        check(detected_cnt == 4'hF, "R8 counter saturates", 64'(detected_cnt), 64'hF);
        bad_en = 0;
    endtask

    initial begin
        logic [30:0] s;
        logic fb;
        s = 31'h2545F491;
        for (int i = 0; i < MEMD; i++) begin
            logic [DW-1:0] w = '0;
            for (int b = 0; b < DW; b++) begin
                fb = s[30] ^ s[27];
                s = {s[29:0], fb};
                w = {w[DW-2:0], fb};
            end
            prbs_tab[i] = w;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_prbs();
        t_pattern();
        t_clamp();
        t_inject();
        t_clear();
        t_badmem();
        t_clear();
        t_saturate();
        t_clear();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule